// File: doc/BRIEF.md
# Stride-Directed Stream Prefetch Buffer

This block is a small, fully associative line buffer placed beside a direct-mapped L1 data cache, between it and the next memory level. Each time the L1 misses, it presents the missed address here. If the line is held in the buffer, the line is returned one cycle later. In both cases, whether the buffer hits or misses, the block schedules a prefetch of the looked-up line plus a programmable stride. This way, every hit re-arms the prefetcher from the address that was just used.

The stride is a signed byte distance held in a configuration register. Its bits below the line size are dropped. With the stride equal to one line (the reset value), the block acts as a sequential stream buffer. With other values it follows strided walks, forward or backward.

Prefetch requests leave one at a time on a valid/ready request port. Fills return on a response port tagged by line address. A lookup whose line is still in flight is held off until that line's fill arrives.

Top module: `stride_prefetch_buf`

## Requirements
- R1: After reset, no entry is valid, no request is raised, no response is given, and the stride equals one line (32 bytes).
- R2: A lookup that is accepted (`lk_valid` and `lk_ready`) raises `rsp_valid` exactly one cycle later. `rsp_hit` is 1 if the looked-up line is held and filled, and then `rsp_data` carries that line's filled data; otherwise `rsp_hit` is 0 and `rsp_data` is 0. No response follows a cycle without an accepted lookup.
- R3: On an accepted lookup that misses, an entry is claimed for the line (lookup line + stride), and a request for that line's byte address is raised. Request addresses are always line aligned (low 5 bits zero).
- R4: On an accepted lookup that hits, the next prefetch target is the hit line plus the stride.
- R5: No entry is claimed and no request is raised when the target line is already held, whether it is filled or still pending.
- R6: `lk_ready` is 0 while the presented address matches a pending entry. It returns to 1 in the cycle after that entry's fill is taken.
- R7: A write on `cfg_we` loads `cfg_stride` with its low 5 bits cleared. The new value is treated as signed two's complement, so negative strides target lower addresses. It takes effect from the next cycle.
- R8: The entry claimed is the lowest-index empty entry. If there is none, it is the least recently used filled entry, where both hits and claims count as uses. If every entry is pending, the prefetch is dropped.
- R9: Each claimed entry is requested exactly once. The request comes from the lowest-index entry not yet sent and stays until `req_ready`. An accepted request is never repeated.
- R10: A fill is taken only when `fill_addr` matches the line of an entry whose request was sent and which is still pending. Any other fill changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Stride register write strobe |
| cfg_stride | input | 32 | Signed byte stride to load |
| lk_valid | input | 1 | L1 miss lookup valid |
| lk_addr | input | 32 | Lookup byte address |
| lk_ready | output | 1 | Low while the address matches a pending line |
| rsp_valid | output | 1 | Lookup response, one cycle after acceptance |
| rsp_hit | output | 1 | Response hit flag |
| rsp_data | output | 64 | Line data on a hit |
| req_valid | output | 1 | Prefetch request valid |
| req_addr | output | 32 | Line-aligned prefetch byte address |
| req_ready | input | 1 | Next level accepts the request |
| fill_valid | input | 1 | Fill response valid |
| fill_addr | input | 32 | Byte address of the returning line |
| fill_data | input | 64 | Returning line data |

## Verification
Bad internal state reaches the ports quickly, and the bench compares all outputs against a behavioural model every cycle. A wrong pending or sent flag shows up in the same cycle: either as a stall on `lk_ready` that should not be there (or a missing one), or as a repeated or missing request on `req_valid`/`req_addr`. A wrong line tag, stored datum or stride shows up one cycle after the next lookup of that line, as a wrong `rsp_hit`/`rsp_data`, or as a wrong prefetch address on the following request. A replacement-order fault stays hidden until the evicted line is looked up again, which is why the bench replays lines after forced eviction.

// File: rtl/stride_pf_pkg.sv
package stride_pf_pkg;
   function automatic int unsigned idx_bits(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/sp_pick.sv
// Lowest-index priority picker.
module sp_pick #(
   parameter int N  = 4,
   parameter int IW = 2
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx
);
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            any = 1'b1;
            idx = IW'(i);
         end
      end
   end
endmodule

// File: rtl/sp_lru_rank.sv
// Recency ranks: 0 = most recent, N-1 = least recent. Two ordered touches per cycle.
module sp_lru_rank #(
   parameter int N  = 4,
   parameter int IW = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            a_en,
   input  logic [IW-1:0]   a_idx,
   input  logic            b_en,
   input  logic [IW-1:0]   b_idx,
   output logic [N*IW-1:0] rank_flat
);
   generate
      if (N == 1) begin : g_single
         assign rank_flat = '0;
      end else begin : g_multi
         logic [IW-1:0] r_q [N];
         logic [IW-1:0] r_a [N];
         logic [IW-1:0] r_b [N];

         always_comb begin
            r_a = r_q;
            if (a_en) begin
               for (int j = 0; j < N; j++)
                  if (IW'(j) != a_idx && r_q[j] < r_q[a_idx]) r_a[j] = r_q[j] + 1'b1;
               r_a[a_idx] = '0;
            end
            r_b = r_a;
            if (b_en) begin
               for (int j = 0; j < N; j++)
                  if (IW'(j) != b_idx && r_a[j] < r_a[b_idx]) r_b[j] = r_a[j] + 1'b1;
               r_b[b_idx] = '0;
            end
         end

         always_ff @(posedge clk) begin
            for (int j = 0; j < N; j++) begin
               if (!rst_n) r_q[j] <= IW'(j);
               else        r_q[j] <= r_b[j];
            end
         end

         for (genvar g = 0; g < N; g++) begin : g_out
            assign rank_flat[g*IW +: IW] = r_q[g];
         end
      end
   endgenerate
endmodule

// File: rtl/stride_prefetch_buf.sv
module stride_prefetch_buf
   import stride_pf_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 32,
   parameter int DATA_W     = 64,
   parameter int ENTRIES    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_stride,
   input  logic              lk_valid,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              lk_ready,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic [DATA_W-1:0] rsp_data,
   output logic              req_valid,
   output logic [ADDR_W-1:0] req_addr,
   input  logic              req_ready,
   input  logic              fill_valid,
   input  logic [ADDR_W-1:0] fill_addr,
   input  logic [DATA_W-1:0] fill_data
);
   localparam int OFF = $clog2(LINE_BYTES);
   localparam int LW  = ADDR_W - OFF;
   localparam int IW  = idx_bits(ENTRIES);

   generate
      if (ENTRIES < 1 || ENTRIES > 5) begin : g_bad_entries
         $error("ENTRIES must be 1 to 5");
      end
      if (LINE_BYTES < 2 || (1 << OFF) != LINE_BYTES) begin : g_bad_line
         $error("LINE_BYTES must be a power of two");
      end
   endgenerate

   logic [ENTRIES-1:0] ent_val, ent_pend, ent_iss;
   logic [LW-1:0]      ent_line [ENTRIES];
   logic [DATA_W-1:0]  ent_data [ENTRIES];
   logic [LW-1:0]      stride_q;

   logic [LW-1:0] lk_line, tgt_line, fill_line;
   assign lk_line   = lk_addr[ADDR_W-1:OFF];
   assign fill_line = fill_addr[ADDR_W-1:OFF];
   assign tgt_line  = lk_line + stride_q;   // modulo add = signed stride

   logic [ENTRIES-1:0] hit_vec, tgt_vec, issue_vec, fill_vec;
   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign hit_vec[g]   = ent_val[g] && ent_line[g] == lk_line;
      assign tgt_vec[g]   = ent_val[g] && ent_line[g] == tgt_line;
      assign issue_vec[g] = ent_val[g] && ent_pend[g] && !ent_iss[g];
      assign fill_vec[g]  = fill_valid && ent_val[g] && ent_pend[g] && ent_iss[g]
                            && ent_line[g] == fill_line;
   end

   logic          hit_any, free_any;
   logic [IW-1:0] hit_idx, free_idx, req_idx;

   sp_pick #(.N(ENTRIES), .IW(IW)) u_hit   (.req(hit_vec),   .any(hit_any),   .idx(hit_idx));
   sp_pick #(.N(ENTRIES), .IW(IW)) u_free  (.req(~ent_val),  .any(free_any),  .idx(free_idx));
   sp_pick #(.N(ENTRIES), .IW(IW)) u_issue (.req(issue_vec), .any(req_valid), .idx(req_idx));

   assign lk_ready = !(|(hit_vec & ent_pend));
   logic accept, buf_hit;
   assign accept  = lk_valid && lk_ready;
   assign buf_hit = accept && hit_any;

   // Victim: oldest filled entry other than the one just hit (it becomes newest).
   logic [ENTRIES*IW-1:0] rank_flat;
   logic [ENTRIES-1:0]    cand;
   logic                  lru_any, alloc;
   logic [IW-1:0]         lru_idx, best_rank, vic_idx;

   always_comb begin
      cand = ent_val & ~ent_pend;
      if (buf_hit) cand[hit_idx] = 1'b0;
      lru_any   = 1'b0;
      lru_idx   = '0;
      best_rank = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (cand[i] && (!lru_any || rank_flat[i*IW +: IW] > best_rank)) begin
            lru_any   = 1'b1;
            lru_idx   = IW'(i);
            best_rank = rank_flat[i*IW +: IW];
         end
      end
      if (!lru_any && buf_hit) begin
         lru_any = 1'b1;
         lru_idx = hit_idx;
      end
      vic_idx = free_any ? free_idx : lru_idx;
      alloc   = accept && !(|tgt_vec) && (free_any || lru_any);
   end

   sp_lru_rank #(.N(ENTRIES), .IW(IW)) u_lru (
      .clk(clk), .rst_n(rst_n),
      .a_en(buf_hit), .a_idx(hit_idx),
      .b_en(alloc),   .b_idx(vic_idx),
      .rank_flat(rank_flat)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ent_val   <= '0;
         ent_pend  <= '0;
         ent_iss   <= '0;
         stride_q  <= LW'(1);
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_data  <= '0;
      end else begin
         if (cfg_we) stride_q <= cfg_stride[ADDR_W-1:OFF];
         for (int i = 0; i < ENTRIES; i++) begin
            if (fill_vec[i]) begin
               ent_data[i] <= fill_data;
               ent_pend[i] <= 1'b0;
            end
            if (req_valid && req_ready && req_idx == IW'(i)) ent_iss[i] <= 1'b1;
            if (alloc && vic_idx == IW'(i)) begin
               ent_val[i]  <= 1'b1;
               ent_pend[i] <= 1'b1;
               ent_iss[i]  <= 1'b0;
               ent_line[i] <= tgt_line;
            end
         end
         rsp_valid <= accept;
         rsp_hit   <= buf_hit;
         rsp_data  <= buf_hit ? ent_data[hit_idx] : '0;
      end
   end

   assign req_addr = {ent_line[req_idx], {OFF{1'b0}}};

   logic unused_low_bits;
   assign unused_low_bits = ^{lk_addr[OFF-1:0], fill_addr[OFF-1:0], cfg_stride[OFF-1:0]};
endmodule

// File: rtl/sp_check.sv
module sp_check #(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 32
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          lk_valid,
   input logic [ADDR_W-1:0]             lk_addr,
   input logic                          lk_ready,
   input logic                          rsp_valid,
   input logic                          rsp_hit,
   input logic                          req_valid,
   input logic [$clog2(LINE_BYTES)-1:0] req_lo,
   input logic                          fill_valid
);
   p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!req_valid && !rsp_valid));

   p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && lk_ready) |=> rsp_valid);

   p_rsp_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(lk_valid && lk_ready) |=> !rsp_valid);

   p_hit_in_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> rsp_valid);

   p_req_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> req_lo == '0);

   p_stall_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && !lk_ready && !fill_valid) ##1 (lk_valid && $stable(lk_addr)) |-> !lk_ready);
endmodule

bind stride_prefetch_buf sp_check #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_sp_check (
   .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
   .lk_ready(lk_ready), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
   .req_valid(req_valid), .req_lo(req_addr[$clog2(LINE_BYTES)-1:0]),
   .fill_valid(fill_valid)
);

// File: tb/stride_prefetch_buf_test.sv
module stride_prefetch_buf_test;
   localparam int N    = 4;
   localparam int LAT  = 3;
   localparam int MASK = (1 << 27) - 1;

   logic        clk = 0, rst_n = 0;
   logic        cfg_we = 0;
   logic [31:0] cfg_stride = 0;
   logic        lk_valid = 0;
   logic [31:0] lk_addr = 0;
   logic        lk_ready, rsp_valid, rsp_hit, req_valid;
   logic [63:0] rsp_data;
   logic [31:0] req_addr;
   logic        req_ready = 1;
   logic        fill_valid = 0;
   logic [31:0] fill_addr = 0;
   logic [63:0] fill_data = 0;

   always #10 clk = ~clk;

   stride_prefetch_buf uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_stride(cfg_stride),
      .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_ready(lk_ready),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
      .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
      .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data)
   );

   int compared = 0, mismatched = 0, cyc = 0;
   string cur = "R1";

   // behavioural model
   bit          m_val[N], m_pend[N], m_iss[N];
   int unsigned m_line[N];
   logic [63:0] m_data[N];
   int          m_ord[$];
   int unsigned m_stride;
   bit          m_rv, m_rh;
   logic [63:0] m_rd;

   int unsigned fq_addr[$];
   int          fq_due[$];
   bit          fill_en = 1;
   bit          foreign = 0;

   function automatic logic [63:0] mem_of(int unsigned a);
      return {a, ~a};
   endfunction

   function automatic int mfind(int unsigned ln);
      for (int i = 0; i < N; i++) if (m_val[i] && m_line[i] == ln) return i;
      return -1;
   endfunction

   function automatic int m_reqi();
      for (int i = 0; i < N; i++) if (m_val[i] && m_pend[i] && !m_iss[i]) return i;
      return -1;
   endfunction

   function automatic bit m_ready();
      int f;
      f = mfind(lk_addr >> 5);
      return !(f >= 0 && m_pend[f]);
   endfunction

   task automatic touch(int x);
      foreach (m_ord[k]) if (m_ord[k] == x) begin m_ord.delete(k); break; end
      m_ord.push_front(x);
   endtask

   task automatic m_reset();
      for (int i = 0; i < N; i++) begin m_val[i] = 0; m_pend[i] = 0; m_iss[i] = 0; end
      m_ord = {};
      for (int i = 0; i < N; i++) m_ord.push_back(i);
      m_stride = 1; m_rv = 0; m_rh = 0; m_rd = 0;
      fq_addr = {}; fq_due = {};
   endtask

   task automatic cmp(string tag, string what, longint got, longint exp);
      compared++;
      if (got != exp) begin
         mismatched++;
         $display("FAIL %s %s cycle %0d: got %h expected %h", tag, what, cyc, got, exp);
      end
   endtask

   task automatic m_step();
      int unsigned ln, tgt;
      int f, ri, v;
      bit acc, hit;
      ln  = lk_addr >> 5;
      f   = mfind(ln);
      acc = lk_valid && m_ready();
      hit = acc && f >= 0;
      tgt = (ln + m_stride) & MASK;
      ri  = m_reqi();
      m_rv = acc; m_rh = hit; m_rd = hit ? m_data[f] : 64'h0;
      v = -1;
      if (hit) touch(f);
      if (acc && mfind(tgt) < 0) begin
         for (int i = 0; i < N; i++) if (!m_val[i]) begin v = i; break; end
         if (v < 0)
            for (int k = m_ord.size() - 1; k >= 0; k--)
               if (m_val[m_ord[k]] && !m_pend[m_ord[k]]) begin v = m_ord[k]; break; end
      end
      if (fill_valid)
         for (int i = 0; i < N; i++)
            if (m_val[i] && m_pend[i] && m_iss[i] && m_line[i] == (fill_addr >> 5)) begin
               m_data[i] = fill_data; m_pend[i] = 0;
            end
      if (ri >= 0 && req_ready) begin
         m_iss[ri] = 1;
         fq_addr.push_back(m_line[ri] << 5);
         fq_due.push_back(cyc + LAT);
      end
      if (v >= 0) begin
         m_val[v] = 1; m_pend[v] = 1; m_iss[v] = 0; m_line[v] = tgt; touch(v);
      end
      if (cfg_we) m_stride = (cfg_stride >> 5) & MASK;
   endtask

   // one cycle: inputs already set at negedge; drive fill, compare, clock model
   task automatic step();
      int ri;
      fill_valid = 0;
      if (foreign) begin
         fill_valid = 1; fill_addr = 32'h7777_0000; fill_data = 64'hdead; foreign = 0;
      end else if (fill_en && fq_addr.size() > 0 && fq_due[0] <= cyc) begin
         fill_valid = 1; fill_addr = fq_addr.pop_front(); void'(fq_due.pop_front());
         fill_data = mem_of(fill_addr);
      end
      #1;
      ri = m_reqi();
      cmp("R6", "lk_ready", lk_ready, m_ready());
      cmp("R2", "rsp_valid", rsp_valid, m_rv);
      cmp("R2", "rsp_hit", rsp_hit, m_rh);
      cmp(cur, "rsp_data", rsp_data, m_rd);
      cmp("R9", "req_valid", req_valid, ri >= 0);
      if (ri >= 0) cmp(cur, "req_addr", req_addr, m_line[ri] << 5);
      @(posedge clk);
      m_step();
      cyc++;
      @(negedge clk);
      cfg_we = 0;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic look(int unsigned a);
      lk_valid = 1; lk_addr = a;
      step();
      while (!m_ready()) step();
      lk_valid = 0;
      step();
   endtask

   task automatic set_stride(int unsigned s);
      cfg_we = 1; cfg_stride = s;
      step();
   endtask

   always @(posedge clk) if (cyc > 20000) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      m_reset();
      @(negedge clk); @(negedge clk);
      cur = "R1";
      step();               // in reset: model already in reset state
      rst_n = 1;
      idle(3);

      cur = "R3";           // stream mode: miss prefetches next line
      look(32'h1000);
      idle(6);
      cur = "R4";           // hit re-arms from the hit line
      look(32'h1020);
      idle(6);
      look(32'h1040);
      look(32'h1060);       // immediately pending: stalls
      idle(6);

      cur = "R6";
      look(32'h2000);
      look(32'h2020);
      idle(4);

      cur = "R7";
      set_stride(32'h47);   // becomes 0x40
      look(32'h3000);
      idle(6);
      set_stride(32'hFFFF_FFC0);
      look(32'h4000);
      idle(6);

      cur = "R5";
      look(32'h4000);       // target 0x3FC0 already held
      look(32'h3FC0);       // hit, target 0x3F80 new
      idle(6);
      look(32'h3FC0);       // hit again, target held: suppressed
      idle(3);

      cur = "R8";
      set_stride(32'h20);
      req_ready = 0;
      look(32'h5000); look(32'h6000); look(32'h7000); look(32'h8000); look(32'h9000);
      idle(3);
      req_ready = 1;
      idle(20);
      look(32'h5020);
      look(32'hA000); look(32'hB000);
      idle(10);
      look(32'h6020); look(32'h7020); look(32'h5020);
      idle(6);

      cur = "R10";
      fill_en = 0;
      look(32'hC000);
      idle(5);
      foreign = 1;
      step();
      lk_valid = 1; lk_addr = 32'hC020;
      step(); step();
      fill_en = 1;
      while (!m_ready()) step();
      step();
      lk_valid = 0;
      idle(4);

      cur = "R3";
      set_stride(32'h0);    // zero stride: target equals the lookup line
      look(32'hD000);
      idle(6);
      look(32'hD000);
      idle(4);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule